// File: doc/BRIEF.md
# Prescaled Countdown Timer with Expiry Vector

This block is a 32-bit down-counter. Its decrement rate comes from the system clock through a power-of-two prescaler, and a divide register sets the prescale factor. The count is loaded by writing the initial-count register. A control word holds three fields: an 8-bit vector, a mask bit, and a mode bit that selects one-shot or periodic operation. When the count reaches zero, the block raises a one-cycle expiry pulse and presents the stored vector beside it, provided the mask bit is clear.

Software writes through a single write port. `wr_sel` chooses the target register. The live count is available at all times on `cur_count`. Periodic mode reloads the initial value on the tick after zero, so each period lasts initial+1 ticks. One-shot mode stops at zero. The block does not prioritise interrupts; it only delivers the expiry pulse and the vector.

Top module: `cntdn_timer`

## Requirements
- R1: A write to the divide register (`wr_sel`=1) stores only data bits 0, 1 and 3 (mask 0xB). Every other bit of the written value has no effect on the tick rate.
- R2: The divide code is {stored bit 3, stored bit 1, stored bit 0}, and the shift is (code+1) mod 8. The count decrements once every 2^shift clocks. Code 7 therefore gives a decrement every clock, and the reset value 0 gives one every 2 clocks.
- R3: In one-shot mode (control bit 17 clear), the count falls by one per tick to zero and then holds at zero.
- R4: In periodic mode (control bit 17 set), a tick with the count at zero reloads the last initial value. The count runs initial, initial-1, ..., 0 and then repeats.
- R5: A write to the initial-count register (`wr_sel`=0) places the value on `cur_count` in the following cycle. It also clears the prescaler phase, so the first decrement comes 2^shift clocks after the write.
- R6: An initial count of zero keeps the count at zero in both modes, and no expiry pulse occurs.
- R7: A tick that moves the count from 1 to 0 raises `irq_pulse` for exactly one cycle, in the first cycle that shows the zero count. The pulse is suppressed when control bit 16 (mask) is set. `irq_vector` always shows control bits 7:0.
- R8: A write with `wr_sel`=3 (current-count position) changes no state.
- R9: A write to the control register (`wr_sel`=2) takes effect on later ticks. Setting bit 17 after a one-shot expiry re-arms the timer, so the next tick reloads the initial value. Setting bit 16 cancels the pulses that would follow.
- R10: After reset, `cur_count` is 0, `irq_pulse` is 0, `irq_vector` is 0, the mask bit is set and the divide register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 initial count, 1 divide, 2 control, 3 current count (ignored) |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Live counter value |
| irq_pulse | output | 1 | One-cycle expiry pulse |
| irq_vector | output | 8 | Vector from the control word |

## Verification
A write made at a clock edge is visible one cycle later. The count after an initial-count write, the stored control fields and the stored divide code all follow this rule. The first decrement after an initial-count write appears 2^shift cycles later, and the expiry pulse appears in the same cycle that the count first reads zero. The bench keeps a behavioural model that is advanced once per clock. It compares the model with the outputs at each falling edge, before driving the next input, so every result is checked in the exact cycle it is due. Pulse totals for the one-shot, masked and zero-count cases are also checked against values worked out by hand.

// File: rtl/cntdn_pkg.sv
package cntdn_pkg;
    typedef enum logic [1:0] {
        SEL_INIT = 2'd0,
        SEL_DIV  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_CUR  = 2'd3
    } reg_sel_e;

    localparam int CTRL_MASK_BIT = 16;
    localparam int CTRL_PER_BIT  = 17;
    localparam int SHIFT_W       = 3;
    localparam logic [3:0] DIV_KEEP = 4'hB;
endpackage

// File: rtl/cntdn_prescale.sv
module cntdn_prescale #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PH_W = (1 << SHIFT_W) - 1;

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [PH_W-1:0] sel_mask;

    always_comb begin
        sel_mask = ~({PH_W{1'b1}} << shift);
        tick     = !restart && ((st_q.phase & sel_mask) == sel_mask);
        st_d     = st_q;
        if (restart) st_d.phase = '0;
        else         st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: with a shift of one or more, ticks never fall on adjacent clocks
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && shift != '0 && !restart) |=> (!tick || shift == '0));
endmodule

// File: rtl/cntdn_core.sv
module cntdn_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic             masked,
    output logic [CNT_W-1:0] count,
    output logic             pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (restart) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = periodic ? init_val : '0;
            end else begin
                st_d.cnt   = st_q.cnt - ONE;
                st_d.pulse = (st_q.cnt == ONE) && !masked;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign pulse = st_q.pulse;

    // R5: a restart shows the written value on the next cycle
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == $past(load_val)));
    // R3: one-shot count at zero stays at zero
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !periodic && count == '0) |=> (count == '0));
    // R4: a tick on a nonzero count lowers it by one
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && count != '0) |=> (count == $past(count) - ONE));
    // R7: the pulse lasts a single cycle and is absent when masked
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    p_pulse_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && masked) |=> !pulse);
    // R6: a zero count never produces a pulse on the next cycle unless it was one
    p_zero_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !restart) |=> !pulse);
endmodule

// File: rtl/cntdn_timer.sv
module cntdn_timer #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cur_count,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);
    import cntdn_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] init;
        logic [3:0]       div;
        logic             mask;
        logic             per;
        logic [VEC_W-1:0] vec;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  wr_init;
    logic  tick;
    logic [SHIFT_W-1:0] shift;

    always_comb begin
        rg_d    = rg_q;
        wr_init = wr_en && (wr_sel == SEL_INIT);
        if (wr_en) begin
            case (wr_sel)
                SEL_INIT: rg_d.init = wr_data;
                SEL_DIV:  rg_d.div  = wr_data[3:0] & DIV_KEEP;
                SEL_CTRL: begin
                    rg_d.mask = wr_data[CTRL_MASK_BIT];
                    rg_d.per  = wr_data[CTRL_PER_BIT];
                    rg_d.vec  = wr_data[VEC_W-1:0];
                end
                default: ;
            endcase
        end
        shift = {rg_q.div[3], rg_q.div[1:0]} + SHIFT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q      <= '0;
            rg_q.mask <= 1'b1;
        end else begin
            rg_q <= rg_d;
        end
    end

    cntdn_prescale #(.SHIFT_W(SHIFT_W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_init),
        .shift   (shift),
        .tick    (tick)
    );

    cntdn_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_init),
        .load_val (wr_data),
        .init_val (rg_q.init),
        .tick     (tick),
        .periodic (rg_q.per),
        .masked   (rg_q.mask),
        .count    (cur_count),
        .pulse    (irq_pulse)
    );

    assign irq_vector = rg_q.vec;

    // R1: bit 2 of the divide register never holds a one
    p_div_bit2_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rg_q.div[2] == 1'b0));
    // R8: a current-count write leaves every register unchanged
    p_cur_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CUR) |=> $stable(rg_q));
    // R7: the vector follows a control write on the next cycle
    p_vec_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL) |=> (irq_vector == $past(wr_data[VEC_W-1:0])));
endmodule

// File: tb/tb_cntdn_timer.sv
module tb_cntdn_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] cur_count;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    always #(CLK_PERIOD/2) clk = ~clk;

    cntdn_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cur_count(cur_count), .irq_pulse(irq_pulse),
        .irq_vector(irq_vector)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int seen_pulses = 0;
    string cur_req = "R10";

    // behavioural reference state
    logic [31:0] m_cnt = 0, m_init = 0;
    logic [3:0]  m_div = 0;
    logic        m_mask = 1, m_per = 0, m_pulse = 0;
    logic [7:0]  m_vec = 0;
    int          m_ph = 0;

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_step(logic en, logic [1:0] sel, logic [31:0] d);
        int code, sh;
        bit tk;
        code = {m_div[3], m_div[1:0]};
        sh   = (code + 1) % 8;
        tk   = ((m_ph + 1) % (1 << sh)) == 0;
        m_pulse = 0;
        if (en && sel == 2'd0) begin
            m_init = d; m_cnt = d; m_ph = 0;
        end else begin
            if (tk) begin
                if (m_cnt == 0) m_cnt = m_per ? m_init : 0;
                else begin
                    if (m_cnt == 1 && !m_mask) m_pulse = 1;
                    m_cnt = m_cnt - 1;
                end
            end
            m_ph = (m_ph + 1) % 128;
        end
        if (en && sel == 2'd1) m_div = d[3:0] & 4'hB;
        if (en && sel == 2'd2) begin
            m_mask = d[16]; m_per = d[17]; m_vec = d[7:0];
        end
    endtask

    // called at a falling edge: compare, drive, advance model, wait a cycle
    task automatic cyc(logic en, logic [1:0] sel, logic [31:0] d);
        check(cur_req, "cur_count", cur_count, m_cnt);
        check(cur_req, "irq_pulse", irq_pulse, m_pulse);
        check(cur_req, "irq_vector", irq_vector, m_vec);
        if (irq_pulse) seen_pulses++;
        wr_en = en; wr_sel = sel; wr_data = d;
        model_step(en, sel, d);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        cyc(1'b1, sel, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check("R10", "reset count", cur_count, 0);
        check("R10", "reset pulse", irq_pulse, 0);
        check("R10", "reset vector", irq_vector, 0);

        // R5 / R3 / R7: one-shot, unmasked, default divide by two
        cur_req = "R5";
        wr(2'd2, 32'h0000_0041);
        wr(2'd0, 32'd5);
        check("R5", "loaded value", cur_count, 5);
        cur_req = "R3";
        seen_pulses = 0;
        idle(24);
        check("R7", "one-shot pulse total", seen_pulses, 1);
        check("R3", "held at zero", cur_count, 0);

        // R1 / R2: divide write 0xFF keeps 0xB -> code 7 -> every clock; periodic
        cur_req = "R2";
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0002_0033);
        wr(2'd0, 32'd4);
        cur_req = "R4";
        idle(30);

        // R2: code 4 (bit 3 only) -> shift 5 -> every 32 clocks
        cur_req = "R2";
        wr(2'd2, 32'h0000_0010);
        wr(2'd1, 32'h0000_0008);
        wr(2'd0, 32'd3);
        idle(140);

        // R1: bit 2 alone is dropped -> code 0 -> every 2 clocks
        cur_req = "R1";
        wr(2'd1, 32'h0000_0004);
        wr(2'd0, 32'd3);
        idle(2);
        check("R1", "bit2 ignored, rate", cur_count, 2);
        idle(8);

        // R8: current-count write ignored
        cur_req = "R8";
        wr(2'd0, 32'd9);
        wr(2'd3, 32'h1234_5678);
        idle(1);
        check("R8", "count after cur write", cur_count, 8);
        idle(20);

        // R6: zero initial count in periodic, unmasked
        cur_req = "R6";
        wr(2'd2, 32'h0002_0022);
        wr(2'd0, 32'd0);
        seen_pulses = 0;
        idle(20);
        check("R6", "zero-count pulses", seen_pulses, 0);
        check("R6", "zero-count value", cur_count, 0);

        // R9: masked periodic reloads but stays quiet
        cur_req = "R9";
        wr(2'd1, 32'h0000_000B);
        wr(2'd2, 32'h0003_0022);
        wr(2'd0, 32'd3);
        seen_pulses = 0;
        idle(20);
        check("R9", "masked pulses", seen_pulses, 0);

        // R9: one-shot expiry, then switch to periodic re-arms
        wr(2'd2, 32'h0000_0055);
        wr(2'd0, 32'd2);
        idle(6);
        check("R9", "expired one-shot", cur_count, 0);
        wr(2'd2, 32'h0002_0055);
        idle(1);
        check("R9", "re-armed reload", cur_count, 2);
        seen_pulses = 0;
        idle(9);
        check("R9", "re-armed pulses", seen_pulses, 3);

        // R2: code 6 (0xA) -> shift 7 -> every 128 clocks
        cur_req = "R2";
        wr(2'd2, 32'h0000_0077);
        wr(2'd1, 32'h0000_000A);
        wr(2'd0, 32'd2);
        idle(127);
        check("R2", "before first slow tick", cur_count, 2);
        idle(1);
        check("R2", "after first slow tick", cur_count, 1);
        idle(140);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule